// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block turns a loop trip count into a series of vector-sized pieces for a downstream vector unit. Given a trip count `n` and a start pulse, it hands out one piece at a time as a starting element index and a length. No piece is longer than the maximum vector length `MVL`. The first piece carries the odd-sized leftover (`n mod MVL`). Every later piece is exactly `MVL` long. Each piece's start index is the previous start plus the previous length, counting from element 1.

A piece is presented with a valid flag and stays on the outputs until the vector unit acknowledges it. The next piece follows directly after that. The final piece is marked with a last flag. A single-cycle done pulse follows its acknowledge. `MVL` is a power of two, so the remainder and the count of full pieces come from slicing the bits of `n`.

Top module: `vlseq_top`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `chunk_valid` and `done` are 0.
- R2: When `n mod MVL` is nonzero, the first piece has `chunk_low` = 1 and `chunk_len` = `n mod MVL`.
- R3: When `n` is a nonzero multiple of `MVL`, no zero-length piece is issued; the first piece has `chunk_low` = 1 and `chunk_len` = `MVL`.
- R4: Every piece after the first has `chunk_len` = `MVL`, and its `chunk_low` equals the previous piece's `chunk_low` plus its `chunk_len`.
- R5: A run issues exactly ceil(n / MVL) pieces, and `chunk_last` is 1 only on the final one.
- R6: While `chunk_valid` is 1 and `chunk_ack` is 0, `chunk_low`, `chunk_len` and `chunk_last` hold their values.
- R7: `done` is 1 for exactly the cycle after the final piece's acknowledge, and `chunk_valid` is 0 in that cycle.
- R8: A start with `n` = 0 issues no piece and raises `done` in the cycle after the start.
- R9: A start pulse that arrives while a piece is outstanding is ignored and does not disturb the run in progress.
- R10: The first piece is valid in the cycle after the start, and each following piece is valid in the cycle after the acknowledge of the one before, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run; sampled only when idle |
| trip_count | input | N_W | Loop trip count `n`, sampled with `start` |
| chunk_ack | input | 1 | Vector unit has finished the current piece |
| chunk_valid | output | 1 | A piece is on the outputs |
| chunk_low | output | N_W | First element index of the piece (1-based) |
| chunk_len | output | $clog2(MVL)+1 | Number of elements in the piece |
| chunk_last | output | 1 | The piece is the final one of the run |
| done | output | 1 | One-cycle pulse after the run completes |

## Verification
A corrupted start index or leftover count shows up on `chunk_low` or `chunk_len` in the first cycle in which a piece is valid. The model compares those outputs on every clock, so the error is seen at once. A wrong count of remaining full pieces changes nothing until near the end of the run. It then appears as `chunk_last` on the wrong piece, or as `done` arriving early or late, and it is caught in the cycle in which the flag should or should not have risen. A stuck state register shows up as a missing piece or a missing done pulse, which the per-cycle comparison catches in the cycle the event was due.

// File: rtl/vlseq_pkg.sv
package vlseq_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

endpackage

// File: rtl/vlseq_split.sv
// Splits a trip count into the first piece length and the number of
// full-length pieces that follow it.
module vlseq_split #(
   parameter int N_W = 16,
   parameter int MVL = 64
) (
   input  logic [N_W-1:0]          trip,
   output logic [$clog2(MVL):0]    first_len,
   output logic [N_W-$clog2(MVL)-1:0] tail_cnt,
   output logic                    empty
);
   localparam int LG    = $clog2(MVL);
   localparam int LEN_W = LG + 1;
   localparam int CNT_W = N_W - LG;

   assign empty = (trip == '0);

   generate
      if (LG == 0) begin : g_unit
         assign first_len = 1'b1;
         assign tail_cnt  = trip - 1'b1;
      end else begin : g_pow
         logic [LG-1:0]    rem;
         logic [CNT_W-1:0] full;
         assign rem  = trip[LG-1:0];
         assign full = trip[N_W-1:LG];
         always_comb begin
            if (rem != '0) begin
               first_len = {1'b0, rem};
               tail_cnt  = full;
            end else begin
               first_len = LEN_W'(MVL);
               tail_cnt  = full - 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/vlseq_cursor.sv
// Holds the current piece and steps it forward on acknowledge.
module vlseq_cursor #(
   parameter int N_W = 16,
   parameter int MVL = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic                       step,
   input  logic [$clog2(MVL):0]       first_len,
   input  logic [N_W-$clog2(MVL)-1:0] tail_in,
   output logic [N_W-1:0]             low,
   output logic [$clog2(MVL):0]       len,
   output logic                       last
);
   localparam int LG    = $clog2(MVL);
   localparam int LEN_W = LG + 1;
   localparam int CNT_W = N_W - LG;

   logic [CNT_W-1:0] tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low    <= '0;
         len    <= '0;
         tail_q <= '0;
      end else if (load) begin
         low    <= N_W'(1);
         len    <= first_len;
         tail_q <= tail_in;
      end else if (step) begin
         low    <= low + N_W'(len);
         len    <= LEN_W'(MVL);
         tail_q <= tail_q - 1'b1;
      end
   end

   assign last = (tail_q == '0);

endmodule

// File: rtl/vlseq_top.sv
module vlseq_top #(
   parameter int N_W = 16,
   parameter int MVL = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [N_W-1:0]       trip_count,
   input  logic                 chunk_ack,
   output logic                 chunk_valid,
   output logic [N_W-1:0]       chunk_low,
   output logic [$clog2(MVL):0] chunk_len,
   output logic                 chunk_last,
   output logic                 done
);
   import vlseq_pkg::*;

   localparam int LG    = $clog2(MVL);
   localparam int LEN_W = LG + 1;
   localparam int CNT_W = N_W - LG;

   generate
      if ((MVL < 1) || ((MVL & (MVL - 1)) != 0)) begin : g_bad_mvl
         $error("vlseq_top: MVL must be a power of two");
      end
      if (N_W <= LG) begin : g_bad_width
         $error("vlseq_top: N_W must exceed log2(MVL)");
      end
   endgenerate

   seq_state_e       state_q;
   logic             done_q;
   logic             accept, take, finish;
   logic [LEN_W-1:0] first_len;
   logic [CNT_W-1:0] tail_cnt;
   logic             empty;

   vlseq_split #(.N_W(N_W), .MVL(MVL)) u_split (
      .trip      (trip_count),
      .first_len (first_len),
      .tail_cnt  (tail_cnt),
      .empty     (empty)
   );

   assign accept = start && (state_q == SEQ_IDLE);
   assign take   = (state_q == SEQ_RUN) && chunk_ack;
   assign finish = take && chunk_last;

   vlseq_cursor #(.N_W(N_W), .MVL(MVL)) u_cursor (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept && !empty),
      .step      (take && !chunk_last),
      .first_len (first_len),
      .tail_in   (tail_cnt),
      .low       (chunk_low),
      .len       (chunk_len),
      .last      (chunk_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            if (empty) done_q  <= 1'b1;
            else       state_q <= SEQ_RUN;
         end else if (finish) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
         end
      end
   end

   assign chunk_valid = (state_q == SEQ_RUN);
   assign done        = done_q;

   // R6
   hold_piece_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_valid && !chunk_ack) |=>
         (chunk_valid && $stable(chunk_low) && $stable(chunk_len) && $stable(chunk_last)));

   // R2
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid |-> ((chunk_len != '0) && (chunk_len <= LEN_W'(MVL))));

   // R4
   full_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_valid && chunk_ack && !chunk_last) |=> (chunk_valid && chunk_len == LEN_W'(MVL)));

   // R7
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_valid && chunk_ack && chunk_last) |=> (done && !chunk_valid));

   // R7
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !chunk_valid);

   // R8
   empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !chunk_valid && trip_count == '0) |=> (done && !chunk_valid));

endmodule

// File: tb/vlseq_top_test.sv
module vlseq_top_test;
   localparam int N_W   = 12;
   localparam int MVL   = 8;
   localparam int LEN_W = $clog2(MVL) + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [N_W-1:0]   trip_count = '0;
   logic             chunk_ack = 1'b0;
   logic             chunk_valid;
   logic [N_W-1:0]   chunk_low;
   logic [LEN_W-1:0] chunk_len;
   logic             chunk_last;
   logic             done;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int ack_gap = 1;
   int ack_cnt = 0;

   int q_low[$];
   int q_len[$];
   bit exp_done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   vlseq_top #(.N_W(N_W), .MVL(MVL)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .trip_count(trip_count),
      .chunk_ack(chunk_ack), .chunk_valid(chunk_valid), .chunk_low(chunk_low),
      .chunk_len(chunk_len), .chunk_last(chunk_last), .done(done)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   // Behavioural reference: a queue of pieces built at start.
   always @(posedge clk) begin
      if (!rst_n) begin
         q_low.delete(); q_len.delete(); exp_done = 1'b0;
      end else begin
         exp_done = 1'b0;
         if (q_low.size() > 0) begin
            if (chunk_ack) begin
               void'(q_low.pop_front()); void'(q_len.pop_front());
               if (q_low.size() == 0) exp_done = 1'b1;
            end
         end else if (start) begin
            int n, lo;
            n  = int'(trip_count);
            lo = 1;
            if (n % MVL != 0) begin
               q_low.push_back(lo); q_len.push_back(n % MVL); lo += n % MVL;
            end
            for (int i = 0; i < n / MVL; i++) begin
               q_low.push_back(lo); q_len.push_back(MVL); lo += MVL;
            end
            if (n == 0) exp_done = 1'b1;
         end
      end
   end

   // Compare every cycle away from the edge, then drive the acknowledge.
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         check("R10 chunk_valid", int'(chunk_valid), int'(q_low.size() > 0));
         check("R7 done", int'(done), int'(exp_done));
         if (q_low.size() > 0 && chunk_valid) begin
            check("R4/R6 chunk_low", int'(chunk_low), q_low[0]);
            check("R2/R3 chunk_len", int'(chunk_len), q_len[0]);
            check("R5 chunk_last", int'(chunk_last), int'(q_low.size() == 1));
         end
      end
      if (chunk_valid) begin
         ack_cnt++;
         chunk_ack = (ack_cnt % ack_gap == 0);
      end else begin
         ack_cnt = 0;
         chunk_ack = 1'b0;
      end
   end

   task automatic kick(input int n);
      @(negedge clk);
      trip_count = N_W'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!done && t < 2000) begin @(negedge clk); t++; end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 valid in reset", int'(chunk_valid), 0);
      check("R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", int'(chunk_valid), 0);
      check("R1 done after reset", int'(done), 0);

      // R8: empty loop
      kick(0);
      check("R8 done after empty start", int'(done), 1);
      check("R8 no piece", int'(chunk_valid), 0);
      @(negedge clk);

      // R2: shorter than one vector
      ack_gap = 1; kick(5);
      check("R10 first piece valid", int'(chunk_valid), 1);
      check("R2 first low", int'(chunk_low), 1);
      check("R2 first len", int'(chunk_len), 5);
      wait_done();

      // R3: exact multiples
      kick(8);  wait_done();
      ack_gap = 2; kick(24); wait_done();

      // R4/R5: leftover first, then full pieces, with held pieces (R6)
      ack_gap = 3; kick(34); wait_done();
      ack_gap = 1; kick(21); wait_done();

      // R9: start while busy is ignored
      ack_gap = 4; kick(19);
      repeat (2) @(negedge clk);
      kick(3);   // model ignores it too
      wait_done();

      // back-to-back: start in the done cycle
      ack_gap = 1; kick(9);
      while (!done) @(negedge clk);
      trip_count = N_W'(7); start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_done();

      ack_gap = 2; kick(4095); wait_done();
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule